// File: doc/BRIEF.md
# Windowed Watchdog With Early Warning

This block watches the software running on a processor and raises a system reset when that software stops servicing it on time. It runs a 7-bit down-counter from the peripheral bus clock. A prescaler turns the bus clock into a slower count tick. Software services the watchdog by writing a new counter value. That write is accepted only inside a window: the counter must already be at or below a programmable window value, and it must not yet have dropped below 0x40. A write that comes too early causes a reset, and so does a missing write that lets the counter fall below 0x40.

One count before the late reset, when the counter reaches 0x40, the block sets a warning flag. If the configuration allows it, the flag also drives an interrupt line, so a handler can still refresh the counter or save state. Software reaches three registers through a simple single-cycle register bus. Once set, the enable bit can only be cleared by a reset. The reset request is a level that stays asserted until the block's own reset input is applied.

Top module: `winwd_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0x007F with the enable bit clear. The configuration register (address 1) reads 0x007F. The status register (address 2) reads 0. `wd_bite` and `warn_irq` are low.
- R2: While enabled, the counter in control bits 6:0 goes down by one every TICK_BASE·2^tb bus cycles, where tb is configuration bits 8:7. The first decrement comes one full period after a control write. While the enable bit is clear, the counter does not change except when written.
- R3: On the tick that brings the counter from 0x41 to 0x40, status bit 0 is set. `warn_irq` is high exactly when status bit 0 is set and configuration bit 9 is set.
- R4: On the tick after the counter reaches 0x40, the counter moves to 0x3F and `wd_bite` rises. After that, `wd_bite` stays high, the counter stops, and control writes are ignored until reset.
- R5: A control write while the block is enabled and the counter is greater than configuration bits 6:0 raises `wd_bite` on the next cycle. A write when the counter is at or below the window, and at or above 0x40, loads bits 6:0 as the new counter value without raising `wd_bite`.
- R6: A control write with bit 7 set and bit 6 clear (for example 0x80) raises `wd_bite` on the next cycle, even when the block was not yet enabled.
- R7: Bit 7 of the control register can only be set by a write. Writing it as 0 while it is set leaves it set, and the counter keeps running.
- R8: Writing 0 to status bit 0 clears the warning flag. Writing 1 to it leaves the flag unchanged.
- R9: The configuration register holds the window in bits 6:0, the prescaler select in bits 8:7 and the interrupt enable in bit 9, and it reads back as written (for example 0x3DF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register select: 0 control, 1 configuration, 2 status |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the register selected by bus_addr |
| wd_bite | output | 1 | Reset request, held until rst_n |
| warn_irq | output | 1 | Early-warning interrupt |

## Verification
The hardest cases to reach are the two edges of the refresh window. A refresh must land on exactly the counter value just above the window, or exactly on it, with the tick phase known. The stimulus polls the counter through the read port on the falling edge and issues the refresh write on the very next rising edge. The counter value judged by the window check is therefore the one just observed. A table sweeps the window and refresh points on both sides of each limit. The warning-to-bite spacing and the tick periods are counted in cycles from the same observed counter changes.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  localparam int CNT_W = 7;
  localparam int CFG_W = 10;

  localparam logic [CNT_W-1:0] WARN_VAL = 7'h40;
  localparam logic [CNT_W-1:0] PRE_WARN = 7'h41;
  localparam logic [CNT_W-1:0] CNT_INIT = 7'h7F;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             irq_en;
    logic [1:0]       tb;
    logic [CNT_W-1:0] window;
  } cfg_t;

  localparam cfg_t CFG_INIT = '{irq_en: 1'b0, tb: 2'd0, window: 7'h7F};

endpackage

// File: rtl/wwd_rst_sync.sv
module wwd_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/wwd_timebase.sv
module wwd_timebase #(
  parameter int TICK_BASE = 4096
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] tb,
  output logic       tick
);

  localparam int DIV_W = $clog2(TICK_BASE * 8 + 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] limit;
  logic             at_limit;

  assign limit    = (DIV_W'(TICK_BASE) << tb) - DIV_W'(1);
  assign at_limit = (div_q == limit);
  assign tick     = run && !restart && at_limit;

  always_comb begin
    div_d = div_q;
    if (!run || restart) div_d = '0;
    else if (at_limit)   div_d = '0;
    else                 div_d = div_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_d;
  end

endmodule

// File: rtl/wwd_core.sv
module wwd_core
  import wwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             stat_wr,
  input  logic             stat_bit,
  input  logic [CNT_W-1:0] window,
  output logic             en_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             bite_q,
  output logic             flag_q
);

  logic             en_d, bite_d, flag_d, flag_set;
  logic [CNT_W-1:0] cnt_d;
  logic             refresh_ok;

  // a refresh is live only until the block has bitten
  assign refresh_ok = ctrl_wr && !bite_q;

  always_comb begin
    en_d     = en_q;
    cnt_d    = cnt_q;
    bite_d   = bite_q;
    flag_set = 1'b0;
    if (!bite_q) begin
      if (refresh_ok) begin
        if (en_q && (cnt_q > window)) bite_d = 1'b1;
        if (ctrl_wdata[7]) en_d = 1'b1;
        cnt_d = ctrl_wdata[CNT_W-1:0];
        if ((en_q || ctrl_wdata[7]) && !ctrl_wdata[6]) bite_d = 1'b1;
      end else if (en_q && tick) begin
        cnt_d = cnt_q - 7'd1;
        if (cnt_q == PRE_WARN) flag_set = 1'b1;
        if (cnt_q == WARN_VAL) bite_d = 1'b1;
      end
    end
    if (flag_set)                  flag_d = 1'b1;
    else if (stat_wr && !stat_bit) flag_d = 1'b0;
    else                           flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cnt_q  <= CNT_INIT;
      bite_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      cnt_q  <= cnt_d;
      bite_q <= bite_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              en_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              flag_q,
  output cfg_t              cfg_q,
  output logic              ctrl_wr,
  output logic [7:0]        ctrl_wdata,
  output logic              stat_wr,
  output logic              stat_bit,
  output logic [DATA_W-1:0] bus_rdata
);

  reg_sel_e sel;
  logic     wr;
  logic     cfg_wr;
  cfg_t     cfg_d;

  assign sel        = reg_sel_e'(bus_addr);
  assign wr         = bus_en && bus_we;
  assign ctrl_wr    = wr && (sel == SEL_CTRL);
  assign cfg_wr     = wr && (sel == SEL_CFG);
  assign stat_wr    = wr && (sel == SEL_STAT);
  assign ctrl_wdata = bus_wdata[7:0];
  assign stat_bit   = bus_wdata[0];

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = cfg_t'(bus_wdata[CFG_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= CFG_INIT;
    else         cfg_q <= cfg_d;
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_CTRL: bus_rdata[7:0]       = {en_q, cnt_q};
      SEL_CFG:  bus_rdata[CFG_W-1:0] = cfg_q;
      SEL_STAT: bus_rdata[0]         = flag_q;
      default:  bus_rdata            = '0;
    endcase
  end

endmodule

// File: rtl/winwd_top.sv
module winwd_top
  import wwd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int TICK_BASE = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_bite,
  output logic              warn_irq
);

  logic             srst_n;
  cfg_t             cfg_q;
  logic             ctrl_wr, stat_wr, stat_bit;
  logic [7:0]       ctrl_wdata;
  logic             en_q, bite_q, flag_q, tick;
  logic [CNT_W-1:0] cnt_q;

  wwd_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (srst_n)
  );

  wwd_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_ni     (srst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .en_q       (en_q),
    .cnt_q      (cnt_q),
    .flag_q     (flag_q),
    .cfg_q      (cfg_q),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stat_wr    (stat_wr),
    .stat_bit   (stat_bit),
    .bus_rdata  (bus_rdata)
  );

  wwd_timebase #(.TICK_BASE(TICK_BASE)) u_tb (
    .clk     (clk),
    .rst_ni  (srst_n),
    .run     (en_q && !bite_q),
    .restart (ctrl_wr),
    .tb      (cfg_q.tb),
    .tick    (tick)
  );

  wwd_core u_core (
    .clk        (clk),
    .rst_ni     (srst_n),
    .tick       (tick),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .stat_wr    (stat_wr),
    .stat_bit   (stat_bit),
    .window     (cfg_q.window),
    .en_q       (en_q),
    .cnt_q      (cnt_q),
    .bite_q     (bite_q),
    .flag_q     (flag_q)
  );

  assign wd_bite  = bite_q;
  assign warn_irq = flag_q && cfg_q.irq_en;

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [6:0] cnt,
  input logic [6:0] window,
  input logic       tick,
  input logic       ctrl_wr,
  input logic [7:0] ctrl_wdata,
  input logic       bite,
  input logic       flag
);

  AST_BITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bite |=> bite); // R4

  AST_LATE_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ctrl_wr && !bite && cnt == 7'h40) |=> (bite && cnt == 7'h3F)); // R4

  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ctrl_wr && !bite && cnt == 7'h41) |=> flag); // R3

  AST_EARLY_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && en && !bite && cnt > window) |=> bite); // R5

  AST_FORCED_BITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[7] && !ctrl_wdata[6]) |=> bite); // R6

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en); // R7

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctrl_wr) |=> $stable(cnt)); // R2

endmodule

bind winwd_top wwd_checker u_chk (
  .clk        (clk),
  .rst_n      (srst_n),
  .en         (en_q),
  .cnt        (cnt_q),
  .window     (cfg_q.window),
  .tick       (tick),
  .ctrl_wr    (ctrl_wr),
  .ctrl_wdata (ctrl_wdata),
  .bite       (bite_q),
  .flag       (flag_q)
);

// File: tb/sim_winwd_top.sv
`timescale 1ns/1ps
module sim_winwd_top;

  localparam int DW = 16;
  localparam int TB_BASE = 4;

  logic          clk, rst_n, bus_en, bus_we;
  logic [1:0]    bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          wd_bite, warn_irq;

  int n_run, n_fail;

  winwd_top #(.DATA_W(DW), .TICK_BASE(TB_BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_bite(wd_bite), .warn_irq(warn_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {config, start count, refresh at count, expect bite}
  localparam logic [24:0] VEC [7] = '{
    {10'h05F, 7'h7F, 7'h60, 1'b1},
    {10'h05F, 7'h7F, 7'h5F, 1'b0},
    {10'h05F, 7'h7F, 7'h41, 1'b0},
    {10'h07F, 7'h7F, 7'h7F, 1'b0},
    {10'h050, 7'h70, 7'h51, 1'b1},
    {10'h050, 7'h70, 7'h50, 1'b0},
    {10'h040, 7'h45, 7'h41, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_cnt(input logic [6:0] target);
    logic [DW-1:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, v);
      if (v[6:0] == target) return;
      @(negedge clk);
    end
  endtask

  task automatic cycles_to_change(output int n);
    logic [DW-1:0] v0, v;
    rd(2'd0, v0);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      n++;
      rd(2'd0, v);
      if (v != v0) return;
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int n;
    n_run = 0; n_fail = 0;
    bus_en = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h007F);
    rd(2'd1, v); chk("R1 cfg", v, 16'h007F);
    rd(2'd2, v); chk("R1 stat", v, 16'h0000);
    chk("R1 bite", {15'b0, wd_bite}, 16'h0);
    chk("R1 irq", {15'b0, warn_irq}, 16'h0);

    // R5 window table
    for (int k = 0; k < 7; k++) begin
      do_reset();
      wr(2'd1, {6'b0, VEC[k][24:15]});
      wr(2'd0, {8'b0, 1'b1, VEC[k][14:8]});
      wait_cnt(VEC[k][7:1]);
      wr(2'd0, 16'h00FF);
      chk("R5 bite after refresh", {15'b0, wd_bite}, {15'b0, VEC[k][0]});
      if (!VEC[k][0]) begin
        rd(2'd0, v);
        chk("R5 reload", v, 16'h00FF);
      end
    end

    // R9 config readback
    do_reset();
    wr(2'd1, 16'h03DF);
    rd(2'd1, v); chk("R9 cfg readback", v, 16'h03DF);

    // R2 tick period per prescaler select
    for (int t = 0; t < 4; t++) begin
      do_reset();
      wr(2'd1, 16'((t << 7) | 16'h7F));
      wr(2'd0, 16'h00FF);
      cycles_to_change(n);
      chk("R2 first period", 16'(n), 16'(TB_BASE << t));
      cycles_to_change(n);
      chk("R2 period", 16'(n), 16'(TB_BASE << t));
    end

    // R3 R4 R8 warning then late bite, tb=1, irq enabled
    do_reset();
    wr(2'd1, 16'h02FF);
    wr(2'd0, 16'h00C2);
    wait_cnt(7'h40);
    rd(2'd2, v); chk("R3 flag at 0x40", v, 16'h0001);
    chk("R3 irq", {15'b0, warn_irq}, 16'h1);
    chk("R4 no bite at 0x40", {15'b0, wd_bite}, 16'h0);
    n = 0;
    while (!wd_bite && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R4 bite one tick later", 16'(n), 16'(TB_BASE * 2));
    rd(2'd0, v); chk("R4 counter 0x3F", v, 16'h00BF);
    wr(2'd0, 16'h00FF);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R4 frozen after bite", v, 16'h00BF);
    chk("R4 bite held", {15'b0, wd_bite}, 16'h1);
    wr(2'd2, 16'h0001);
    rd(2'd2, v); chk("R8 write 1 keeps flag", v, 16'h0001);
    wr(2'd2, 16'h0000);
    rd(2'd2, v); chk("R8 write 0 clears flag", v, 16'h0000);
    chk("R8 irq cleared", {15'b0, warn_irq}, 16'h0);

    // R3 flag without interrupt enable
    do_reset();
    wr(2'd1, 16'h007F);
    wr(2'd0, 16'h00C1);
    wait_cnt(7'h40);
    rd(2'd2, v); chk("R3 flag no irq_en", v, 16'h0001);
    chk("R3 irq masked", {15'b0, warn_irq}, 16'h0);

    // R2 disabled counter holds
    do_reset();
    repeat (50) @(negedge clk);
    rd(2'd0, v); chk("R2 idle hold", v, 16'h007F);
    wr(2'd0, 16'h003F);
    repeat (30) @(negedge clk);
    rd(2'd0, v); chk("R2 idle load", v, 16'h003F);
    chk("R2 idle no bite", {15'b0, wd_bite}, 16'h0);

    // R7 enable sticky
    do_reset();
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h007F);
    rd(2'd0, v); chk("R7 enable kept", {15'b0, v[7]}, 16'h1);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R7 still counting", 16'(v[6:0] != 7'h7F), 16'h1);
    chk("R7 no bite", {15'b0, wd_bite}, 16'h0);

    // R6 forced bite
    do_reset();
    wr(2'd0, 16'h00FF);
    wr(2'd0, 16'h0080);
    chk("R6 force enabled", {15'b0, wd_bite}, 16'h1);
    do_reset();
    chk("R1 bite cleared", {15'b0, wd_bite}, 16'h0);
    wr(2'd0, 16'h0080);
    chk("R6 force from idle", {15'b0, wd_bite}, 16'h1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule